// File: doc/BRIEF.md
# Multiplexed ADC Register Controller

This block sits between a 32-bit register bus and a multiplexed 16-bit converter. It has three jobs. First, it drives a 12-bit analog switch configuration that routes one input pair to the converter front end. Second, it guards that switch configuration with a one-shot unlock key. Third, it paces conversions with a timer. Typical switch codes are 0x601, 0x602, 0x604, 0x608, 0x610, 0x620, 0x640 and 0x680. Each code selects one routing, and the block passes the written value through unchanged.

Software never starts a conversion explicitly. Every read of the result register returns the status and data that existed before the read, then clears the ready flag and starts a fresh conversion. Any result that has not been collected is thrown away. A conversion completes only after two conditions hold. The conversion time for the selected clock divisor must have run out. The settling interval, started by the last accepted switch write, must also have elapsed. Both durations are parameters counted in module clock cycles. The defaults assume a 1 MHz module clock:
- divisor 16 gives about 925 conversions per second and 2 ms settling;
- divisor 4 gives about 3750 conversions per second and 500 us settling.

The converter itself is a behavioural stub. At completion it captures `sample_in` as a signed two's-complement word, nominally in the range -25000 to +25000. The register bus carries a request in one cycle and has no back-pressure: every request with `bus_valid` high is taken in that cycle. Each read is answered exactly one cycle later with `bus_rvalid`, which cannot be stalled.

Top module: `adc_regctl`

## Requirements
- R1: After reset the switch output is 0, the lock is engaged (the lock register reads 0), the ready flag is clear, and the mode register reads 0, which means divisor 16.
- R2: A write of 0x000000AA to offset 0x20 unlocks the switch register for the next bus access only. A switch write at offset 0x18 made as that next access takes effect, and a repeated key write re-arms the unlock. While unlocked, offset 0x20 reads 1.
- R3: A switch write made while locked leaves `sw_cfg` unchanged. Any access other than a key write that follows a key write relocks the register, so the lock register then reads 0.
- R4: A read is answered in the following cycle with `bus_rvalid`. The result word at offset 0x08 has the ready flag in bit 31, zeros in bits 30:16, and the most recently completed sample in bits 15:0.
- R5: A read of offset 0x08 returns the state before the read. It clears the ready flag and restarts the conversion, discarding any result not yet read.
- R6: When a conversion completes, the ready flag sets and `sample_in` is captured as-is, including negative values such as 0x9E58 (-25000).
- R7: Bit 0 of the mode register at offset 0x10 selects the divisor: 0 means divisor 16, with CONV_SLOW cycles per conversion; 1 means divisor 4, with CONV_FAST cycles. The divisor used is the one in force when the conversion is triggered.
- R8: After an accepted switch write, no conversion completes until the settling interval has elapsed. That interval is SETTLE_SLOW cycles with divisor 16 and SETTLE_FAST cycles with divisor 4.
- R9: Offset 0x18 reads the switch configuration in its low 12 bits, offset 0x10 reads the mode bit, and any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request, accepted in the same cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid, one cycle after a read request |
| bus_rdata | output | 32 | Read response data |
| sample_in | input | 16 | Sample supplied to the converter stub |
| sw_cfg | output | 12 | Analog switch configuration to the front end |

## Verification
Each of these internal faults shows up at the ports within a bounded time:
- A stuck or long-lived unlock flag lets a switch write through after an intervening access. This appears on `sw_cfg` one cycle later.
- A ready flag that the trigger fails to clear appears in bit 31 of the very next result read.
- A settling counter loaded with the wrong divisor, or ignored altogether, shows up as bit 31 being set in a read placed inside the settling window.
- A conversion timer on the wrong divisor shows up as bit 31 being clear in a read placed between the fast and slow conversion times.

The bench places its reads well away from these boundaries, so the result does not depend on the exact completion cycle.

// File: rtl/adc_regctl_pkg.sv
package adc_regctl_pkg;

  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_RESULT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SWITCH = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 8'h20;

  localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h0000_00AA;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_RESULT,
    TGT_MODE,
    TGT_SWITCH,
    TGT_LOCK
  } reg_tgt_e;

  function automatic reg_tgt_e decode_ofs(input logic [ADDR_W-1:0] ofs);
    case (ofs)
      OFS_RESULT: return TGT_RESULT;
      OFS_MODE:   return TGT_MODE;
      OFS_SWITCH: return TGT_SWITCH;
      OFS_LOCK:   return TGT_LOCK;
      default:    return TGT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/adc_swlock.sv
module adc_swlock
  import adc_regctl_pkg::*;
#(
  parameter int SW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  reg_tgt_e         acc_tgt,
  input  logic [BUS_W-1:0] acc_wdata,
  output logic [SW_W-1:0]  sw_cfg,
  output logic             unlocked,
  output logic             sw_load
);

  logic key_hit;

  assign key_hit = acc_valid && acc_write && (acc_tgt == TGT_LOCK) &&
                   (acc_wdata == UNLOCK_KEY);
  assign sw_load = acc_valid && acc_write && (acc_tgt == TGT_SWITCH) && unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      sw_cfg   <= '0;
    end else begin
      if (acc_valid) begin
        unlocked <= key_hit;
      end
      if (sw_load) begin
        sw_cfg <= acc_wdata[SW_W-1:0];
      end
    end
  end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned CONV_SLOW   = 1081,
  parameter int unsigned CONV_FAST   = 267,
  parameter int unsigned SETTLE_SLOW = 2000,
  parameter int unsigned SETTLE_FAST = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_sel,
  input  logic conv_start,
  input  logic settle_start,
  output logic conv_done,
  output logic settling
);

  localparam int unsigned MAX_CONV = (CONV_SLOW > CONV_FAST) ? CONV_SLOW : CONV_FAST;
  localparam int unsigned MAX_SET  = (SETTLE_SLOW > SETTLE_FAST) ? SETTLE_SLOW : SETTLE_FAST;
  localparam int unsigned MAX_ALL  = (MAX_CONV > MAX_SET) ? MAX_CONV : MAX_SET;
  localparam int          CW       = $clog2(MAX_ALL + 1);

  logic [CW-1:0] conv_cnt;
  logic [CW-1:0] settle_cnt;
  logic          active;
  logic [CW-1:0] conv_len;
  logic [CW-1:0] settle_len;

  assign conv_len   = fast_sel ? CW'(CONV_FAST) : CW'(CONV_SLOW);
  assign settle_len = fast_sel ? CW'(SETTLE_FAST) : CW'(SETTLE_SLOW);
  assign settling   = (settle_cnt != '0);
  assign conv_done  = active && (conv_cnt == '0) && !settling &&
                      !conv_start && !settle_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settle_cnt <= '0;
    end else if (settle_start) begin
      settle_cnt <= settle_len;
    end else if (settling) begin
      settle_cnt <= settle_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      conv_cnt <= '0;
    end else if (conv_start) begin
      active   <= 1'b1;
      conv_cnt <= conv_len;
    end else begin
      if (conv_done) begin
        active <= 1'b0;
      end
      if (conv_cnt != '0) begin
        conv_cnt <= conv_cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] sample_in,
  output logic              rdy,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      data <= '0;
    end else if (conv_start) begin
      rdy <= 1'b0;
    end else if (conv_done) begin
      rdy  <= 1'b1;
      data <= sample_in;
    end
  end

endmodule

// File: rtl/adc_regctl.sv
module adc_regctl
  import adc_regctl_pkg::*;
#(
  parameter int          SW_W        = 12,
  parameter int          DATA_W      = 16,
  parameter int unsigned CONV_SLOW   = 1081,
  parameter int unsigned CONV_FAST   = 267,
  parameter int unsigned SETTLE_SLOW = 2000,
  parameter int unsigned SETTLE_FAST = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  input  logic [DATA_W-1:0] sample_in,
  output logic [SW_W-1:0]   sw_cfg
);

  localparam int PAD_W = BUS_W - 1 - DATA_W;

  reg_tgt_e         tgt;
  logic             rd_req;
  logic             wr_req;
  logic             conv_start;
  logic             conv_done;
  logic             settling;
  logic             sw_load;
  logic             unlocked;
  logic             rdy;
  logic [DATA_W-1:0] data;
  logic             fast_q;
  logic [BUS_W-1:0] rd_word;

  assign tgt        = decode_ofs(bus_addr);
  assign rd_req     = bus_valid && !bus_write;
  assign wr_req     = bus_valid && bus_write;
  assign conv_start = rd_req && (tgt == TGT_RESULT);

  adc_swlock #(.SW_W(SW_W)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (bus_valid),
    .acc_write (bus_write),
    .acc_tgt   (tgt),
    .acc_wdata (bus_wdata),
    .sw_cfg    (sw_cfg),
    .unlocked  (unlocked),
    .sw_load   (sw_load)
  );

  adc_conv_timer #(
    .CONV_SLOW   (CONV_SLOW),
    .CONV_FAST   (CONV_FAST),
    .SETTLE_SLOW (SETTLE_SLOW),
    .SETTLE_FAST (SETTLE_FAST)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .fast_sel     (fast_q),
    .conv_start   (conv_start),
    .settle_start (sw_load),
    .conv_done    (conv_done),
    .settling     (settling)
  );

  adc_conv_stub #(.DATA_W(DATA_W)) u_conv (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .sample_in  (sample_in),
    .rdy        (rdy),
    .data       (data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
    end else if (wr_req && (tgt == TGT_MODE)) begin
      fast_q <= bus_wdata[0];
    end
  end

  always_comb begin
    rd_word = '0;
    case (tgt)
      TGT_RESULT: rd_word = {rdy, {PAD_W{1'b0}}, data};
      TGT_MODE:   rd_word = {{(BUS_W-1){1'b0}}, fast_q};
      TGT_SWITCH: rd_word = {{(BUS_W-SW_W){1'b0}}, sw_cfg};
      TGT_LOCK:   rd_word = {{(BUS_W-1){1'b0}}, unlocked};
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) begin
        bus_rdata <= rd_word;
      end
    end
  end

endmodule

// File: rtl/adc_regctl_chk.sv
module adc_regctl_chk
  import adc_regctl_pkg::*;
#(
  parameter int SW_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_valid,
  input logic            bus_write,
  input logic [7:0]      bus_addr,
  input logic [31:0]     bus_wdata,
  input logic            bus_rvalid,
  input logic [SW_W-1:0] sw_cfg,
  input logic            unlocked,
  input logic            rdy,
  input logic            settling
);

  logic key_wr;
  assign key_wr = bus_valid && bus_write && (bus_addr == OFS_LOCK) &&
                  (bus_wdata == UNLOCK_KEY);

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid); // R4

  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_write)); // R4

  AST_TRIGGER_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == OFS_RESULT) |=> !rdy); // R5

  AST_LOCKED_SW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(sw_cfg)); // R3

  AST_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !key_wr) |=> !unlocked); // R2

  AST_NO_READY_WHILE_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
    settling |=> !$rose(rdy)); // R8

endmodule

bind adc_regctl adc_regctl_chk #(.SW_W(SW_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .sw_cfg     (sw_cfg),
  .unlocked   (unlocked),
  .rdy        (rdy),
  .settling   (settling)
);

// File: tb/adc_regctl_bench.sv
`timescale 1ns/1ps
module adc_regctl_bench;

  localparam int CS = 40;
  localparam int CF = 10;
  localparam int SS = 120;
  localparam int SF = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [15:0] sample_in = 16'h1234;
  logic [11:0] sw_cfg;

  int vectors = 0;
  int miscompares = 0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t sb_q[$];

  always #4 clk = ~clk;

  adc_regctl #(
    .SW_W(12), .DATA_W(16),
    .CONV_SLOW(CS), .CONV_FAST(CF), .SETTLE_SLOW(SS), .SETTLE_FAST(SF)
  ) u_adc_regctl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .sample_in(sample_in), .sw_cfg(sw_cfg)
  );

  // monitor: pops one expected item per read response
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      vectors++;
      if (sb_q.size() == 0) begin
        miscompares++;
        $display("FAIL unexpected response rdata=%h expected none", bus_rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          miscompares++;
          $display("FAIL %s rdata=%h expected %h", it.req, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    sb_item_t it;
    it.exp = e; it.req = req;
    sb_q.push_back(it);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_sw(input logic [11:0] e, input string req);
    vectors++;
    if (sw_cfg !== e) begin
      miscompares++;
      $display("FAIL %s sw_cfg=%h expected %h", req, sw_cfg, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired, pending=%0d expected 0", sb_q.size());
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_sw(12'h000, "R1");
    rd(8'h10, 32'h0, "R1 mode");
    rd(8'h20, 32'h0, "R1 lock");
    rd(8'h08, 32'h0, "R1 ready");
    idle(CS + 20);
    rd(8'h08, 32'h8000_1234, "R6 R4 slow completion");
    rd(8'h08, 32'h0000_1234, "R5 ready cleared");
    idle(CS + 20);

    // R3 locked write ignored
    wr(8'h18, 32'h608);
    check_sw(12'h000, "R3 locked");

    // R2 key then switch
    wr(8'h20, 32'hAA);
    wr(8'h18, 32'h608);
    check_sw(12'h608, "R2 unlocked write");

    // R3 intervening access relocks
    wr(8'h20, 32'hAA);
    rd(8'h18, 32'h608, "R9 switch readback");
    wr(8'h18, 32'h680);
    check_sw(12'h608, "R3 relocked");

    // R2 repeated key re-arms
    wr(8'h20, 32'hAA);
    wr(8'h20, 32'hAA);
    wr(8'h18, 32'h640);
    check_sw(12'h640, "R2 rearm");

    // R8 slow settling blocks completion
    sample_in = 16'h9E58;
    rd(8'h08, 32'h8000_1234, "R5 old result");
    idle(CS + 20);
    rd(8'h08, 32'h0000_1234, "R8 settling slow");
    idle(SS + 30);
    rd(8'h08, 32'h8000_9E58, "R6 negative sample");

    // R7 fast divisor
    wr(8'h10, 32'h1);
    rd(8'h10, 32'h1, "R9 mode readback");
    sample_in = 16'h61A8;
    rd(8'h08, 32'h0000_9E58, "R7 slow pending");
    idle(CF + 5);
    rd(8'h08, 32'h8000_61A8, "R7 fast completion");

    // R8 fast settling
    wr(8'h20, 32'hAA);
    wr(8'h18, 32'h620);
    check_sw(12'h620, "R2 fast switch");
    sample_in = 16'h0001;
    rd(8'h08, 32'h0000_61A8, "R5 pending");
    idle(CF + 5);
    rd(8'h08, 32'h0000_61A8, "R8 settling fast");
    idle(SF + 10);
    rd(8'h08, 32'h8000_0001, "R8 fast settle done");

    // R9 unmapped, lock status
    rd(8'h04, 32'h0, "R9 unmapped");
    wr(8'h20, 32'hAA);
    rd(8'h20, 32'h1, "R2 lock open");
    rd(8'h20, 32'h0, "R3 lock closed");
    wr(8'h18, 32'h604);
    check_sw(12'h620, "R3 after relock");

    idle(3);
    vectors++;
    if (sb_q.size() != 0) begin
      miscompares++;
      $display("FAIL R4 missing responses=%0d expected 0", sb_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule